// File: doc/BRIEF.md
# Gated Serial Message Fetch Controller

This block fetches one serial message from an external sensor each time the host asks for it. The host presents a six-bit command code. When that code matches the configured request value and the block is idle, it raises a request line toward the sensor. The sensor answers by raising a gate and then sending 32 data bits, most significant first. Each bit is timed by a free-running bit clock that the block derives from its system clock. The block withdraws the request as soon as it sees the gate, and it samples one bit per bit-clock period while the gate is high.

Incoming bits pass through a three-stage delay before they enter a 27-bit holding register. After 32 samples, the holding register therefore contains message bits 29 down to 3. When the gate falls after a full message, the block replays the holding register toward the host, most significant first, one bit per bit-clock period, with a strobe on each bit. It then pulses done. It pulses an error flag instead if the sensor never raises the gate, or if the gate drops before the message is complete.

The default settings assume a 120 MHz system clock, which gives a 1.2 MHz bit clock with a 100 ns high pulse. All inputs are assumed synchronous to the system clock.

Top module: `msg_fetch_ctrl`

## Requirements
- R1: The bit clock `bclk_o` repeats every DIV system cycles and is high for the first PULSE cycles of each period. It runs from the end of reset onward, in every controller state.
- R2: A command with `cmd_valid_i` high and `cmd_code_i` equal to REQ_CODE, presented while idle, sets `req_o` high on the next clock edge. Any other code leaves `req_o` low.
- R3: While `req_o` is high, the first cycle in which `gate_i` is high makes `req_o` fall on the next clock edge.
- R4: While `gate_i` is high, `sdata_i` is sampled once per bit-clock period, SAMPLE_OFS cycles after the period starts. Bit 31 of the message is sampled first. Only the first MSG_BITS samples are kept, and any later bits under the same gate are ignored.
- R5: The samples travel through a DELAY_BITS-deep delay before they enter a REG_BITS-wide register. With the default settings, after a 32-bit message the register holds message bits 29 down to 3.
- R6: After the gate falls on a full message, the register is sent on `sout_o` as REG_BITS bits, most significant first. Each bit is marked by a one-cycle `sout_stb_o`, and successive strobes are exactly DIV cycles apart.
- R7: `done_o` pulses for one cycle on the cycle after the final strobe, and the controller then accepts a new request.
- R8: If `gate_i` stays low for GATE_TIMEOUT cycles after `req_o` rises, `err_o` pulses for one cycle in that cycle and `req_o` returns low.
- R9: If `gate_i` falls before MSG_BITS samples have been taken, `err_o` pulses once, no bits are sent, and the controller returns to idle.
- R10: Matching commands that arrive during capture or during output have no effect: `req_o` stays low.
- R11: During and right after reset, `req_o`, `sout_stb_o`, `done_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid_i | input | 1 | Command code is valid this cycle |
| cmd_code_i | input | 6 | Six-bit command code from the host |
| gate_i | input | 1 | Sensor message gate |
| sdata_i | input | 1 | Sensor serial data |
| bclk_o | output | 1 | Generated bit clock toward the sensor |
| req_o | output | 1 | Message request toward the sensor |
| sout_o | output | 1 | Serial data toward the host |
| sout_stb_o | output | 1 | One-cycle strobe marking each valid `sout_o` bit |
| done_o | output | 1 | One-cycle pulse when output completes |
| err_o | output | 1 | One-cycle pulse on gate timeout or short message |

## Verification
The capture path is tested with four message patterns. An irregular mix of ones and zeros checks bit order. A pattern that has ones only in the top two and bottom three bits must produce all zeros, which proves exactly which bits the delay chain drops at each end. Its complement must produce all ones. A 34-bit burst under one gate checks that extra bits are ignored. Command patterns are also varied: wrong codes while idle, and the correct code during capture and during output. These separate true triggering from re-triggering. Missing-gate and short-gate replies show that each error path returns cleanly to idle and that a later fetch still works.

// File: rtl/msg_fetch_pkg.sv
package msg_fetch_pkg;

    localparam int unsigned CODE_W = 6;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_GATE,
        ST_CAPTURE,
        ST_SEND
    } fetch_state_e;

    // per-system-cycle timing strobes derived from the bit clock counter
    typedef struct packed {
        logic sample;   // point in the bit period where sensor data is stable
        logic emit;     // point in the bit period where an output bit advances
    } bit_tick_t;

    // width able to hold the value n
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/bitclk_gen.sv
module bitclk_gen
    import msg_fetch_pkg::*;
#(
    parameter int unsigned DIV        = 100,
    parameter int unsigned PULSE      = 12,
    parameter int unsigned SAMPLE_OFS = 30
) (
    input  logic      clk,
    input  logic      rst,
    output logic      bclk_o,
    output bit_tick_t tick_o
);
    localparam int unsigned CW = cnt_width(DIV - 1);

    logic [CW-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst)                          phase <= '0;
        else if (phase == CW'(DIV - 1))   phase <= '0;
        else                              phase <= phase + 1'b1;
    end

    assign bclk_o        = (phase < CW'(PULSE));
    assign tick_o.sample = (phase == CW'(SAMPLE_OFS));
    assign tick_o.emit   = (phase == '0);

    // R1: end of a period is always followed by a new high pulse
    p_wrap_rise_r1: assert property (@(posedge clk) disable iff (rst)
        (phase == CW'(DIV - 1)) |=> $rose(bclk_o));

endmodule

// File: rtl/capture_chain.sv
module capture_chain
    import msg_fetch_pkg::*;
#(
    parameter int unsigned MSG_BITS   = 32,
    parameter int unsigned DELAY_BITS = 3,
    parameter int unsigned REG_BITS   = 27
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr_i,
    input  logic                sample_i,
    input  logic                sdata_i,
    output logic                full_o,
    output logic [REG_BITS-1:0] data_o
);
    localparam int unsigned NW = cnt_width(MSG_BITS);

    logic [NW-1:0] taken;
    logic          shift_en;
    logic          into_reg;

    assign full_o   = (taken == NW'(MSG_BITS));
    assign shift_en = sample_i && !full_o;

    generate
        if (DELAY_BITS > 0) begin : g_delay
            logic [DELAY_BITS-1:0] dly;
            always_ff @(posedge clk) begin
                if (rst || clr_i)  dly <= '0;
                else if (shift_en) dly <= (dly << 1) | DELAY_BITS'(sdata_i);
            end
            assign into_reg = dly[DELAY_BITS-1];
        end else begin : g_direct
            assign into_reg = sdata_i;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            taken  <= '0;
            data_o <= '0;
        end else if (shift_en) begin
            taken  <= taken + 1'b1;
            data_o <= {data_o[REG_BITS-2:0], into_reg};
        end
    end

    // R4: once the message count is reached the register is frozen
    p_full_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (full_o && !clr_i) |=> $stable(data_o));

endmodule

// File: rtl/out_shifter.sv
module out_shifter
    import msg_fetch_pkg::*;
#(
    parameter int unsigned REG_BITS = 27
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load_i,
    input  logic [REG_BITS-1:0] data_i,
    input  logic                tick_i,
    output logic                sout_o,
    output logic                stb_o,
    output logic                busy_o
);
    localparam int unsigned RW = cnt_width(REG_BITS);

    logic [REG_BITS-1:0] shreg;
    logic [RW-1:0]       left;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg  <= '0;
            left   <= '0;
            sout_o <= 1'b0;
            stb_o  <= 1'b0;
        end else begin
            stb_o <= 1'b0;
            if (load_i) begin
                shreg <= data_i;
                left  <= RW'(REG_BITS);
            end else if (tick_i && left != '0) begin
                sout_o <= shreg[REG_BITS-1];
                stb_o  <= 1'b1;
                shreg  <= shreg << 1;
                left   <= left - 1'b1;
            end
        end
    end

    assign busy_o = (left != '0);

    // R6: a strobe is only ever produced from a pending bit
    p_stb_after_busy_r6: assert property (@(posedge clk) disable iff (rst)
        stb_o |-> $past(busy_o));

endmodule

// File: rtl/msg_fetch_ctrl.sv
module msg_fetch_ctrl
    import msg_fetch_pkg::*;
#(
    parameter logic [5:0]  REQ_CODE     = 6'h2D,
    parameter int unsigned DIV          = 100,
    parameter int unsigned PULSE        = 12,
    parameter int unsigned SAMPLE_OFS   = 30,
    parameter int unsigned MSG_BITS     = 32,
    parameter int unsigned DELAY_BITS   = 3,
    parameter int unsigned REG_BITS     = 27,
    parameter int unsigned GATE_TIMEOUT = 1200
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid_i,
    input  logic [5:0] cmd_code_i,
    input  logic       gate_i,
    input  logic       sdata_i,
    output logic       bclk_o,
    output logic       req_o,
    output logic       sout_o,
    output logic       sout_stb_o,
    output logic       done_o,
    output logic       err_o
);
    localparam int unsigned TW = cnt_width(GATE_TIMEOUT);

    fetch_state_e        state;
    bit_tick_t           tick;
    logic [TW-1:0]       wait_cnt;
    logic                start, load, full, busy;
    logic [REG_BITS-1:0] held;

    bitclk_gen #(.DIV(DIV), .PULSE(PULSE), .SAMPLE_OFS(SAMPLE_OFS)) u_bclk (
        .clk(clk), .rst(rst), .bclk_o(bclk_o), .tick_o(tick)
    );

    capture_chain #(.MSG_BITS(MSG_BITS), .DELAY_BITS(DELAY_BITS), .REG_BITS(REG_BITS)) u_cap (
        .clk(clk), .rst(rst), .clr_i(start),
        .sample_i(state == ST_CAPTURE && gate_i && tick.sample),
        .sdata_i(sdata_i), .full_o(full), .data_o(held)
    );

    out_shifter #(.REG_BITS(REG_BITS)) u_out (
        .clk(clk), .rst(rst), .load_i(load), .data_i(held), .tick_i(tick.emit),
        .sout_o(sout_o), .stb_o(sout_stb_o), .busy_o(busy)
    );

    assign start = (state == ST_IDLE) && cmd_valid_i && (cmd_code_i == REQ_CODE);
    assign load  = (state == ST_CAPTURE) && !gate_i && full;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            req_o    <= 1'b0;
            wait_cnt <= '0;
            done_o   <= 1'b0;
            err_o    <= 1'b0;
        end else begin
            done_o <= 1'b0;
            err_o  <= 1'b0;
            unique case (state)
                ST_IDLE: if (start) begin
                    state    <= ST_WAIT_GATE;
                    req_o    <= 1'b1;
                    wait_cnt <= '0;
                end
                ST_WAIT_GATE: begin
                    if (gate_i) begin
                        state <= ST_CAPTURE;
                        req_o <= 1'b0;
                    end else if (wait_cnt == TW'(GATE_TIMEOUT - 1)) begin
                        state <= ST_IDLE;
                        req_o <= 1'b0;
                        err_o <= 1'b1;
                    end else begin
                        wait_cnt <= wait_cnt + 1'b1;
                    end
                end
                ST_CAPTURE: if (!gate_i) begin
                    if (full) state <= ST_SEND;
                    else begin
                        state <= ST_IDLE;
                        err_o <= 1'b1;
                    end
                end
                ST_SEND: if (!busy) begin
                    state  <= ST_IDLE;
                    done_o <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R3: the request is withdrawn one cycle after the gate is seen
    p_req_drop_r3: assert property (@(posedge clk) disable iff (rst)
        (req_o && gate_i) |=> !req_o);
    // R2: no request is pending while idle
    p_req_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !req_o);
    // R7: completion and error never coincide
    p_pulse_excl_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done_o, err_o}));
    // R8: an error leaves no request standing
    p_err_noreq_r8: assert property (@(posedge clk) disable iff (rst)
        err_o |-> !req_o);
    // R6: output strobes appear only during the send phase
    p_stb_send_r6: assert property (@(posedge clk) disable iff (rst)
        sout_stb_o |-> (state == ST_SEND));

endmodule

// File: tb/msg_fetch_ctrl_bench.sv
module msg_fetch_ctrl_bench;
    localparam logic [5:0]  REQ     = 6'h2D;
    localparam int unsigned DIV     = 100;
    localparam int unsigned PULSE   = 12;
    localparam int unsigned OFS     = 30;
    localparam int unsigned TIMEOUT = 1200;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_valid = 1'b0;
    logic [5:0] cmd_code = '0;
    logic gate = 1'b0, sdata = 1'b0;
    logic bclk, req, sout, stb, done, err;

    always #5 clk = ~clk;

    msg_fetch_ctrl #(.REQ_CODE(REQ), .DIV(DIV), .PULSE(PULSE), .SAMPLE_OFS(OFS),
                     .MSG_BITS(32), .DELAY_BITS(3), .REG_BITS(27),
                     .GATE_TIMEOUT(TIMEOUT)) u_msg_fetch_ctrl (
        .clk(clk), .rst(rst), .cmd_valid_i(cmd_valid), .cmd_code_i(cmd_code),
        .gate_i(gate), .sdata_i(sdata), .bclk_o(bclk), .req_o(req),
        .sout_o(sout), .sout_stb_o(stb), .done_o(done), .err_o(err)
    );

    int errors = 0, checks = 0, cyc = 0;
    int nstb, ndone, nerr, last_stb, done_at, gap_bad;
    logic [26:0] got;

    always @(posedge clk) cyc++;

    always @(negedge clk) if (!rst) begin
        if (stb) begin
            if (nstb > 0 && cyc - last_stb != DIV) gap_bad++;
            got = {got[25:0], sout};
            nstb++;
            last_stb = cyc;
        end
        if (done) begin ndone++; done_at = cyc; end
        if (err) nerr++;
    end

    task automatic check(input bit ok, input string rq, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic clear_obs();
        @(posedge clk);
        nstb = 0; ndone = 0; nerr = 0; last_stb = 0; done_at = 0; gap_bad = 0; got = '0;
    endtask

    task automatic issue_cmd(input logic [5:0] code);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = code;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_code = '0;
    endtask

    task automatic wait_rise();
        logic p;
        p = bclk;
        forever begin
            @(negedge clk);
            if (bclk && !p) break;
            p = bclk;
        end
    endtask

    task automatic measure_bclk(input string tag);
        int n, h;
        logic seen_low;
        wait_rise();
        n = 1; h = 1; seen_low = 1'b0;
        forever begin
            @(negedge clk);
            if (bclk && seen_low) break;
            if (bclk) h++; else seen_low = 1'b1;
            n++;
        end
        check(h == PULSE, "R1", {tag, " high width"}, h, PULSE);
        check(n == DIV, "R1", {tag, " period"}, n, DIV);
    endtask

    // sensor model: bits sent MSB first, bit i = pattern[33-i]
    task automatic sensor_reply(input logic [33:0] pattern, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            wait_rise();
            gate = 1'b1;
            sdata = pattern[33 - i];
            if (i == 0) begin
                @(negedge clk);
                check(req == 1'b0, "R3", "request after gate", req, 0);
            end
        end
        wait_rise();
        gate = 1'b0; sdata = 1'b0;
    endtask

    task automatic wait_end(input int limit);
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (ndone > 0 || nerr > 0) break;
        end
    endtask

    task automatic check_output(input logic [31:0] m, input string tag);
        check(nerr == 0, "R4", {tag, " no error"}, nerr, 0);
        check(nstb == 27, "R6", {tag, " bit count"}, nstb, 27);
        check(got == m[29:3], "R5", {tag, " data"}, got, m[29:3]);
        check(gap_bad == 0, "R6", {tag, " strobe spacing"}, gap_bad, 0);
        check(ndone == 1, "R7", {tag, " done pulses"}, ndone, 1);
        check(done_at - last_stb == 1, "R7", {tag, " done timing"}, done_at - last_stb, 1);
    endtask

    task automatic t_fetch(input logic [31:0] m, input logic [1:0] extra,
                           input int nbits, input string tag);
        clear_obs();
        issue_cmd(REQ);
        check(req == 1'b1, "R2", {tag, " request raised"}, req, 1);
        sensor_reply({m, extra}, nbits);
        wait_end(4000);
        check_output(m, tag);
    endtask

    task automatic t_wrong_codes();
        logic [5:0] bad [3] = '{6'h2C, 6'h00, ~REQ};
        foreach (bad[k]) begin
            issue_cmd(bad[k]);
            check(req == 1'b0, "R2", "wrong code immediate", req, 0);
            repeat (20) @(negedge clk);
            check(req == 1'b0, "R2", "wrong code later", req, 0);
        end
    endtask

    task automatic t_busy_ignore();
        logic [31:0] m = 32'h6B1E_D24C;
        clear_obs();
        issue_cmd(REQ);
        fork
            sensor_reply({m, 2'b00}, 32);
            begin
                repeat (800) @(negedge clk);
                issue_cmd(REQ);
                check(req == 1'b0, "R10", "code during capture", req, 0);
            end
            measure_bclk("during capture");
        join
        issue_cmd(REQ);
        check(req == 1'b0, "R10", "code during output", req, 0);
        wait_end(4000);
        check_output(m, "busy");
    endtask

    task automatic t_timeout();
        int n = 0;
        clear_obs();
        issue_cmd(REQ);
        while (!err && n <= TIMEOUT + 10) begin
            @(negedge clk);
            n++;
        end
        check(n == TIMEOUT, "R8", "timeout cycles", n, TIMEOUT);
        check(req == 1'b0, "R8", "request dropped", req, 0);
        repeat (3) @(negedge clk);
        check(nerr == 1, "R8", "single error pulse", nerr, 1);
    endtask

    task automatic t_short_gate();
        clear_obs();
        issue_cmd(REQ);
        sensor_reply({32'hFFFF_FFFF, 2'b00}, 20);
        repeat (5) @(negedge clk);
        check(nerr == 1, "R9", "short message error", nerr, 1);
        repeat (3000) @(negedge clk);
        check(nstb == 0, "R9", "no output bits", nstb, 0);
        check(ndone == 0, "R9", "no done", ndone, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        check(req == 0 && stb == 0 && done == 0 && err == 0, "R11", "in reset",
              {req, stb, done, err}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(req == 0 && stb == 0 && done == 0 && err == 0, "R11", "after reset",
              {req, stb, done, err}, 0);
        measure_bclk("idle");
        t_wrong_codes();
        t_fetch(32'hA5C3_96E1, 2'b00, 32, "mixed");
        t_fetch(32'hC000_0007, 2'b00, 32, "edges only");
        t_fetch(32'h3FFF_FFF8, 2'b00, 32, "middle only");
        t_fetch(32'h1234_5678, 2'b11, 34, "R4 overlong");
        t_busy_ignore();
        t_timeout();
        t_short_gate();
        t_fetch(32'h5A5A_A5A5, 2'b00, 32, "after errors");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule